// File: doc/BRIEF.md
# Video Write FIFO Access Throttle

This block paces host writes into a display controller through a four-entry write FIFO. It does not hold any data. It keeps count of how many host writes are still pending and retires them at a fixed spacing measured in master clock cycles. That spacing comes from the average number of host slots per scanline. A scanline lasts 3420 master cycles. The narrow 32-cell mode gives 16 slots per line and the wide 40-cell mode gives 18. A word write to byte-wide video RAM takes two byte accesses, so the spacing doubles for that target.

The host side presents a write strobe, the current target code and the display-mode bit. A free-running master cycle counter, supplied from outside, is the time base. The block returns three things: a FIFO-empty flag for the status word, a full signal that the host treats as a stall, and the pending count. Per-pixel slot timing and the blanking-period exclusion are not modelled. Only the averaged per-line rate is.

Top module: `vwf_throttle`

## Requirements
- R1: During and right after reset (active-low `rst_n`, asynchronous), the pending count is 0, `fifo_empty` is 1 and `fifo_full` is 0.
- R2: With `wide_mode`=1 and a target other than video RAM, a pending entry retires when 190 or more master cycles have elapsed since the timing reference; at 189 it is still pending.
- R3: With `wide_mode`=0 and a target other than video RAM, the spacing is 214 master cycles.
- R4: When the low four bits of `tgt_code` equal 4'h1 (video RAM), the spacing doubles: 380 in wide mode, 428 in narrow mode. Bits above bit 3 play no part in this decision, and any other low-nibble value uses the single spacing.
- R5: In one cycle the number of entries retired is floor(elapsed / spacing), limited to the pending count, so the count never goes below zero.
- R6: The FIFO holds 4 entries. With 4 pending, `fifo_full` is 1 and a write with no retirement in the same cycle is dropped. A write in a cycle that also retires an entry is accepted.
- R7: `fifo_empty` goes to 0 on the clock after an accepted write and returns to 1 once the pending count reaches zero.
- R8: A change of `wide_mode` or `tgt_code` sets the spacing used for retirement from the next clock edge on, including for entries that are already pending.
- R9: Elapsed time is `mcyc` minus the reference, taken modulo 2^16, so it stays correct when the counter wraps.
- R10: A write into an empty FIFO sets the reference to the current `mcyc`. After that, each retired entry advances the reference by exactly one spacing, and later writes do not move it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_stb | input | 1 | Host write request, one per cycle |
| tgt_code | input | 6 | Current access target code; low nibble 4'h1 = video RAM |
| wide_mode | input | 1 | 1 = wide 40-cell mode, 0 = narrow 32-cell mode |
| mcyc | input | 16 | Free-running master cycle counter |
| fifo_empty | output | 1 | No writes pending |
| fifo_full | output | 1 | Four writes pending; host must stall |
| pend_cnt | output | 3 | Number of pending writes (0 to 4) |

## Verification
The pending count is a port, so a wrong timing reference or a wrong spacing shows up as a retirement that comes one or more master cycles early or late. Each such retirement is visible on the clock after the edge where it should have happened. The vectors place one sample on each side of every threshold (189/190, 213/214, 379/380, 427/428), so an off-by-one error shows within a single sample. A stale spacing register after a mode or target change keeps an entry pending past the point where it should clear, or clears it too soon, and this appears on the next sampled edge. A wrong drop decision when full leaves the count one too high or one too low for the rest of the sequence.

// File: rtl/vwf_pkg.sv
package vwf_pkg;

  // Average spacing between host slots, rounded to the nearest cycle.
  function automatic int unsigned slot_gap(int unsigned line_len, int unsigned slots);
    return (line_len + slots / 2) / slots;
  endfunction

  // Spacing for a mode / target pair; byte-wide RAM needs two accesses per word.
  function automatic int unsigned pick_gap(logic wide, logic byte_ram,
                                           int unsigned line_len,
                                           int unsigned slots_narrow,
                                           int unsigned slots_wide);
    int unsigned g;
    g = wide ? slot_gap(line_len, slots_wide) : slot_gap(line_len, slots_narrow);
    if (byte_ram) g = g * 2;
    return g;
  endfunction

  // Whole spacings contained in an elapsed span.
  function automatic int unsigned drain_quot(int unsigned span, int unsigned gap);
    return (gap == 0) ? 0 : span / gap;
  endfunction

endpackage

// File: rtl/vwf_intv_sel.sv
module vwf_intv_sel #(
  parameter int unsigned CW           = 16,
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned LINE_CYC     = 3420,
  parameter int unsigned SLOTS_NARROW = 16,
  parameter int unsigned SLOTS_WIDE   = 18,
  parameter logic [3:0]  RAM_CODE     = 4'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic              wide_mode,
  output logic [CW-1:0]     intv
);
  import vwf_pkg::*;

  localparam logic [CODE_W-1:0] NIB_MASK = CODE_W'(4'hF);
  localparam logic [CODE_W-1:0] RAM_MATCH = CODE_W'(RAM_CODE);
  localparam logic [CW-1:0] RST_GAP =
    CW'(pick_gap(1'b1, 1'b0, LINE_CYC, SLOTS_NARROW, SLOTS_WIDE));

  logic          byte_tgt;
  logic [CW-1:0] gap_nxt;

  // Only the low nibble selects the target memory.
  assign byte_tgt = ((tgt_code & NIB_MASK) == RAM_MATCH);
  assign gap_nxt  = CW'(pick_gap(wide_mode, byte_tgt, LINE_CYC, SLOTS_NARROW, SLOTS_WIDE));

  // R8: registered, so a mode/target change applies from the next edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) intv <= RST_GAP;
    else        intv <= gap_nxt;
  end

endmodule

// File: rtl/vwf_drain_calc.sv
module vwf_drain_calc #(
  parameter int unsigned CW    = 16,
  parameter int unsigned CNT_W = 3
) (
  input  logic [CW-1:0]    mcyc,
  input  logic [CW-1:0]    ref_t,
  input  logic [CW-1:0]    intv,
  input  logic [CNT_W-1:0] pend,
  output logic [CW-1:0]    elapsed,
  output logic [CNT_W-1:0] drain_n
);
  import vwf_pkg::*;

  logic [CW-1:0] quot;

  // R9: modular difference survives counter wrap.
  assign elapsed = mcyc - ref_t;
  assign quot    = CW'(drain_quot(32'(elapsed), 32'(intv)));

  // R5: never retire more than is pending.
  always_comb begin
    if (quot >= CW'(pend)) drain_n = pend;
    else                   drain_n = quot[CNT_W-1:0];
  end

endmodule

// File: rtl/vwf_occupancy.sv
module vwf_occupancy #(
  parameter int unsigned CW    = 16,
  parameter int unsigned DEPTH = 4,
  parameter int unsigned CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_stb,
  input  logic [CW-1:0]    mcyc,
  input  logic [CW-1:0]    intv,
  input  logic [CNT_W-1:0] drain_n,
  output logic [CNT_W-1:0] pend,
  output logic [CW-1:0]    ref_t,
  output logic             acc_evt
);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] after_drain;
  logic [CW-1:0]    ref_step;

  assign after_drain = pend - drain_n;
  // R6: a slot freed in this cycle can take the write.
  assign acc_evt     = wr_stb && (after_drain < DEPTH_C);
  assign ref_step    = CW'(CW'(drain_n) * intv);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend  <= '0;
      ref_t <= '0;
    end else begin
      pend <= after_drain + CNT_W'(acc_evt);
      // R10: restart timing on a write into an empty FIFO, else advance by whole spacings.
      if (acc_evt && (after_drain == '0)) ref_t <= mcyc;
      else if (drain_n != '0)             ref_t <= ref_t + ref_step;
    end
  end

endmodule

// File: rtl/vwf_throttle.sv
module vwf_throttle #(
  parameter int unsigned CW           = 16,
  parameter int unsigned CODE_W       = 6,
  parameter int unsigned DEPTH        = 4,
  parameter int unsigned LINE_CYC     = 3420,
  parameter int unsigned SLOTS_NARROW = 16,
  parameter int unsigned SLOTS_WIDE   = 18,
  parameter logic [3:0]  RAM_CODE     = 4'h1,
  localparam int unsigned CNT_W       = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_stb,
  input  logic [CODE_W-1:0] tgt_code,
  input  logic              wide_mode,
  input  logic [CW-1:0]     mcyc,
  output logic              fifo_empty,
  output logic              fifo_full,
  output logic [CNT_W-1:0]  pend_cnt
);
  // Internal events brought out as named wires for the bound checker.
  logic [CW-1:0]    intv;
  logic [CW-1:0]    ref_t;
  logic [CW-1:0]    elapsed;
  logic [CNT_W-1:0] drain_n;
  logic             acc_evt;

  vwf_intv_sel #(
    .CW(CW), .CODE_W(CODE_W), .LINE_CYC(LINE_CYC),
    .SLOTS_NARROW(SLOTS_NARROW), .SLOTS_WIDE(SLOTS_WIDE), .RAM_CODE(RAM_CODE)
  ) u_intv (
    .clk(clk), .rst_n(rst_n), .tgt_code(tgt_code), .wide_mode(wide_mode), .intv(intv)
  );

  vwf_drain_calc #(.CW(CW), .CNT_W(CNT_W)) u_drain (
    .mcyc(mcyc), .ref_t(ref_t), .intv(intv), .pend(pend_cnt),
    .elapsed(elapsed), .drain_n(drain_n)
  );

  vwf_occupancy #(.CW(CW), .DEPTH(DEPTH), .CNT_W(CNT_W)) u_occ (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .mcyc(mcyc), .intv(intv),
    .drain_n(drain_n), .pend(pend_cnt), .ref_t(ref_t), .acc_evt(acc_evt)
  );

  assign fifo_empty = (pend_cnt == '0);
  assign fifo_full  = (pend_cnt == CNT_W'(DEPTH));

endmodule

// File: rtl/vwf_throttle_chk.sv
module vwf_throttle_chk #(
  parameter int unsigned CW           = 16,
  parameter int unsigned DEPTH        = 4,
  parameter int unsigned CNT_W        = 3,
  parameter int unsigned LINE_CYC     = 3420,
  parameter int unsigned SLOTS_NARROW = 16,
  parameter int unsigned SLOTS_WIDE   = 18
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_stb,
  input logic             fifo_empty,
  input logic             fifo_full,
  input logic [CNT_W-1:0] pend_cnt,
  input logic [CNT_W-1:0] drain_n,
  input logic             acc_evt,
  input logic [CW-1:0]    elapsed,
  input logic [CW-1:0]    intv
);
  import vwf_pkg::*;

  localparam logic [CW-1:0] G_WN = CW'(pick_gap(1'b1, 1'b0, LINE_CYC, SLOTS_NARROW, SLOTS_WIDE));
  localparam logic [CW-1:0] G_NN = CW'(pick_gap(1'b0, 1'b0, LINE_CYC, SLOTS_NARROW, SLOTS_WIDE));
  localparam logic [CW-1:0] G_WB = CW'(pick_gap(1'b1, 1'b1, LINE_CYC, SLOTS_NARROW, SLOTS_WIDE));
  localparam logic [CW-1:0] G_NB = CW'(pick_gap(1'b0, 1'b1, LINE_CYC, SLOTS_NARROW, SLOTS_WIDE));

  AST_PEND_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cnt <= CNT_W'(DEPTH)); // R6

  AST_DROP_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_full && wr_stb && drain_n == '0) |=> (pend_cnt == CNT_W'(DEPTH))); // R6

  AST_EMPTY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    acc_evt |=> !fifo_empty); // R7

  AST_EMPTY_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && drain_n == pend_cnt && !acc_evt) |=> fifo_empty); // R7

  AST_NO_EARLY_DRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_empty && elapsed < intv) |=> (pend_cnt >= $past(pend_cnt))); // R2

  AST_GROW_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ({1'b0, pend_cnt} <= {1'b0, $past(pend_cnt)} + 1'b1)); // R5

  AST_GAP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (intv == G_WN) || (intv == G_NN) || (intv == G_WB) || (intv == G_NB)); // R4

endmodule

bind vwf_throttle vwf_throttle_chk #(
  .CW(CW), .DEPTH(DEPTH), .CNT_W(CNT_W), .LINE_CYC(LINE_CYC),
  .SLOTS_NARROW(SLOTS_NARROW), .SLOTS_WIDE(SLOTS_WIDE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .pend_cnt(pend_cnt), .drain_n(drain_n),
  .acc_evt(acc_evt), .elapsed(elapsed), .intv(intv)
);

// File: tb/sim_vwf_throttle.sv
module sim_vwf_throttle;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_stb = 1'b0;
  logic [5:0]  tgt_code = 6'h00;
  logic        wide_mode = 1'b1;
  logic [15:0] mcyc = 16'd0;
  logic        fifo_empty, fifo_full;
  logic [2:0]  pend_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk; // 125 MHz

  vwf_throttle u0 (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .tgt_code(tgt_code),
    .wide_mode(wide_mode), .mcyc(mcyc), .fifo_empty(fifo_empty),
    .fifo_full(fifo_full), .pend_cnt(pend_cnt)
  );

  // {wr, code[5:0], wide, mcyc[15:0], expected pending[2:0], requirement[3:0]}
  localparam int NV = 41;
  localparam logic [30:0] VEC [0:NV-1] = '{
    {1'b1, 6'h00, 1'b1, 16'd1000,  3'd1, 4'd7},  // R7 first write into empty
    {1'b1, 6'h00, 1'b1, 16'd1001,  3'd2, 4'd6},
    {1'b1, 6'h00, 1'b1, 16'd1002,  3'd3, 4'd6},
    {1'b1, 6'h00, 1'b1, 16'd1003,  3'd4, 4'd6},  // R6 full
    {1'b1, 6'h00, 1'b1, 16'd1004,  3'd4, 4'd6},  // R6 dropped
    {1'b0, 6'h00, 1'b1, 16'd1189,  3'd4, 4'd2},  // R2 one short
    {1'b0, 6'h00, 1'b1, 16'd1190,  3'd3, 4'd2},  // R2 at 190
    {1'b1, 6'h00, 1'b1, 16'd1380,  3'd3, 4'd10}, // R10 reference advanced
    {1'b1, 6'h00, 1'b1, 16'd1381,  3'd4, 4'd6},
    {1'b1, 6'h00, 1'b1, 16'd1570,  3'd4, 4'd6},  // R6 write with same-cycle drain
    {1'b0, 6'h00, 1'b1, 16'd2330,  3'd0, 4'd5},  // R5 four at once
    {1'b0, 6'h00, 1'b1, 16'd3000,  3'd0, 4'd7},
    {1'b1, 6'h00, 1'b1, 16'd3000,  3'd1, 4'd7},
    {1'b0, 6'h00, 1'b1, 16'd4000,  3'd0, 4'd5},  // R5 clamp at zero
    {1'b0, 6'h00, 1'b0, 16'd4001,  3'd0, 4'd3},
    {1'b1, 6'h00, 1'b0, 16'd5000,  3'd1, 4'd3},
    {1'b0, 6'h00, 1'b0, 16'd5213,  3'd1, 4'd3},  // R3 one short
    {1'b0, 6'h00, 1'b0, 16'd5214,  3'd0, 4'd3},  // R3 at 214
    {1'b0, 6'h01, 1'b0, 16'd5215,  3'd0, 4'd4},
    {1'b1, 6'h01, 1'b0, 16'd6000,  3'd1, 4'd4},
    {1'b0, 6'h01, 1'b0, 16'd6427,  3'd1, 4'd4},  // R4 narrow RAM 428
    {1'b0, 6'h01, 1'b0, 16'd6428,  3'd0, 4'd4},
    {1'b0, 6'h01, 1'b1, 16'd6429,  3'd0, 4'd4},
    {1'b1, 6'h01, 1'b1, 16'd7000,  3'd1, 4'd4},
    {1'b0, 6'h01, 1'b1, 16'd7379,  3'd1, 4'd4},  // R4 wide RAM 380
    {1'b0, 6'h01, 1'b1, 16'd7380,  3'd0, 4'd4},
    {1'b0, 6'h21, 1'b1, 16'd7381,  3'd0, 4'd4},
    {1'b1, 6'h21, 1'b1, 16'd8000,  3'd1, 4'd4},
    {1'b0, 6'h21, 1'b1, 16'd8379,  3'd1, 4'd4},  // R4 upper code bits ignored
    {1'b0, 6'h21, 1'b1, 16'd8380,  3'd0, 4'd4},
    {1'b0, 6'h03, 1'b1, 16'd8381,  3'd0, 4'd4},
    {1'b1, 6'h03, 1'b1, 16'd9000,  3'd1, 4'd4},
    {1'b0, 6'h03, 1'b1, 16'd9190,  3'd0, 4'd4},  // R4 other code not doubled
    {1'b1, 6'h00, 1'b1, 16'd9500,  3'd1, 4'd8},
    {1'b0, 6'h00, 1'b0, 16'd9600,  3'd1, 4'd8},
    {1'b0, 6'h00, 1'b0, 16'd9700,  3'd1, 4'd8},  // R8 new 214 gap used
    {1'b0, 6'h00, 1'b0, 16'd9714,  3'd0, 4'd8},
    {1'b0, 6'h00, 1'b1, 16'd65500, 3'd0, 4'd9},
    {1'b1, 6'h00, 1'b1, 16'd65500, 3'd1, 4'd9},
    {1'b0, 6'h00, 1'b1, 16'd153,   3'd1, 4'd9},  // R9 wrap, 189 elapsed
    {1'b0, 6'h00, 1'b1, 16'd154,   3'd0, 4'd9}   // R9 wrap, 190 elapsed
  };

  task automatic check(input int req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic check_state(input int req, input int exp_pend);
    check(req, "pend_cnt", int'(pend_cnt), exp_pend);
    check(req, "fifo_empty", int'(fifo_empty), int'(exp_pend == 0));
    check(req, "fifo_full", int'(fifo_full), int'(exp_pend == 4));
  endtask

  task automatic drive(input logic w, input logic [5:0] c, input logic wd, input logic [15:0] m);
    @(negedge clk);
    wr_stb = w; tgt_code = c; wide_mode = wd; mcyc = m;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    check_state(1, 0);
    rst_n = 1'b1;
    drive(1'b0, 6'h00, 1'b1, 16'd10);
    @(posedge clk); #1;
    check_state(1, 0);
    drive(1'b0, 6'h00, 1'b1, 16'd11);

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][30], VEC[i][29:24], VEC[i][23], VEC[i][22:7]);
      @(posedge clk); #1;
      check_state(int'(VEC[i][3:0]), int'(VEC[i][6:4]));
    end

    // R1 reset in the middle of activity
    drive(1'b1, 6'h00, 1'b1, 16'd20000);
    drive(1'b1, 6'h00, 1'b1, 16'd20001);
    @(posedge clk); #1;
    check_state(6, 2);
    @(negedge clk);
    wr_stb = 1'b0;
    rst_n = 1'b0;
    #1;
    check_state(1, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7 a single write after reset is visible
    drive(1'b1, 6'h00, 1'b1, 16'd30000);
    @(posedge clk); #1;
    check_state(7, 1);
    drive(1'b0, 6'h00, 1'b1, 16'd30190);
    @(posedge clk); #1;
    check_state(2, 0);

    finish_run();
  end

endmodule